// File: doc/BRIEF.md
# Table-Fetch Sine Oscillator

This block produces one stereo audio sample per sample tick from a single-period sine table that lives in external memory. It keeps an unsigned 32-bit fractional phase and forms a 14-bit table index from the phase as it stood before the current step. It then adds the step to the phase, which wraps modulo one full cycle. For each tick it issues one word read at a byte address equal to a host-supplied base plus four times the index. It accepts the response after any number of cycles, scales the signed entry by a host gain and drives the same value on both channels.

The host supplies a precomputed phase step of f/48000·2^32 in place of a frequency. The step for 440 Hz is 39370534. Gain is an unsigned Q1.15 value, and 0.25 is 0x2000. Table entries are signed Q1.31 words. A 24-bit result keeps the top of the scaled product. A tick that arrives while an earlier read is still unanswered marks a sticky underrun.

Top module: `wt_osc`

## Requirements
- R1: While rst_n is low, rd_req, out_valid and underrun are 0 and both channels read 0. After reset the phase is 0.
- R2: Each tick sampled high produces rd_req high for exactly one cycle, one clock after the tick. With no tick, rd_req stays low.
- R3: rd_addr equals base_addr + 4·idx, where idx is phase bits [31:18] taken before the phase is advanced. The first read after reset therefore uses idx 0.
- R4: On each tick the phase gains the phase_inc value sampled with that tick, wrapping modulo 2^32.
- R5: When rsp_valid arrives for an outstanding read, out_valid is high for one cycle on the next clock. out_l and out_r both equal floor(signed(rsp_data)·gain / 2^23), with gain an unsigned Q1.15 value.
- R6: A scaled result above 8388607 gives 0x7FFFFF, and one below -8388608 gives 0x800000.
- R7: The response may come any number of cycles after the request, including the cycle rd_req is seen. Until it comes, out_valid stays low and both channels keep their previous values.
- R8: A tick while a read is still unanswered sets underrun. A response arriving in the same cycle as the tick counts as answered. The tick still issues its read, responses are consumed in order, and underrun stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample tick, one cycle per sample |
| phase_inc | input | 32 | Phase step per sample (fraction of a period times 2^32) |
| gain | input | 16 | Output gain, unsigned Q1.15 |
| base_addr | input | 32 | Byte address of table entry 0 |
| rd_req | output | 1 | Read request pulse |
| rd_addr | output | 32 | Byte address of the requested entry |
| rsp_valid | input | 1 | Read response strobe |
| rsp_data | input | 32 | Table entry, signed Q1.31 |
| out_valid | output | 1 | New sample strobe |
| out_l | output | 24 | Left channel sample |
| out_r | output | 24 | Right channel sample |
| underrun | output | 1 | Sticky flag: a tick arrived before the previous read was answered |

## Verification
On every cycle, the assertions check four things: each request follows a tick by one clock, each request address keeps the alignment of the base, a sample strobe appears only after a response, and the channels hold between strobes. They also check that underrun only rises on a tick and never falls. Only the bench scenarios can show the values: the phase arithmetic across wrap, the pre-advance index, the scaled and saturated samples, and the decision that a response arriving with a tick avoids underrun.

// File: rtl/wt_osc.sv
module wt_osc #(
  parameter int PH_W      = 32,
  parameter int IDX_W     = 14,
  parameter int ADDR_W    = 32,
  parameter int WORD_W    = 32,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 15,
  parameter int OUT_W     = 24,
  parameter int PEND_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [PH_W-1:0]   phase_inc,
  input  logic [GAIN_W-1:0] gain,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_data,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_l,
  output logic [OUT_W-1:0]  out_r,
  output logic              underrun
);
  localparam int PROD_W = WORD_W + GAIN_W + 1;
  localparam int SHIFT  = GAIN_FRAC + WORD_W - OUT_W;
  localparam logic signed [PROD_W-1:0] HI = $signed((PROD_W'(1) << (OUT_W-1)) - PROD_W'(1));
  localparam logic signed [PROD_W-1:0] LO = -$signed(PROD_W'(1) << (OUT_W-1));

  logic [PH_W-1:0]   phase;
  logic [PEND_W-1:0] pend;
  logic [OUT_W-1:0]  smp;

  wire                    rsp_ok = rsp_valid && (pend != '0);
  wire [PEND_W-1:0]       left   = pend - PEND_W'(rsp_ok);
  wire [IDX_W-1:0]        idx    = phase[PH_W-1 -: IDX_W];

  logic signed [PROD_W-1:0] prod, shifted;
  logic [OUT_W-1:0]         sat;

  assign prod    = $signed(rsp_data) * $signed({1'b0, gain});
  assign shifted = prod >>> SHIFT;
  assign sat     = (shifted > HI) ? HI[OUT_W-1:0] :
                   (shifted < LO) ? LO[OUT_W-1:0] : shifted[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= '0;
      pend      <= '0;
      rd_req    <= 1'b0;
      rd_addr   <= '0;
      out_valid <= 1'b0;
      smp       <= '0;
      underrun  <= 1'b0;
    end else begin
      rd_req    <= tick;
      out_valid <= rsp_ok;
      pend      <= left + PEND_W'(tick);
      if (tick) begin
        rd_addr <= base_addr + ADDR_W'({idx, 2'b00});
        phase   <= phase + phase_inc;
        if (left != '0) underrun <= 1'b1;
      end
      if (rsp_ok) smp <= sat;
    end
  end

  assign out_l = smp;
  assign out_r = smp;
endmodule

// File: rtl/wt_osc_chk.sv
module wt_osc_chk #(
  parameter int ADDR_W = 32,
  parameter int OUT_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [ADDR_W-1:0] base_addr,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rsp_valid,
  input logic              out_valid,
  input logic [OUT_W-1:0]  out_l,
  input logic [OUT_W-1:0]  out_r,
  input logic              underrun
);
  // R2
  req_follows_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (rd_req == $past(tick)));
  // R3
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr[1:0] == $past(base_addr[1:0])));
  // R5
  valid_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(rsp_valid));
  // R7
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && $past(rst_n)) |-> ($stable(out_l) && $stable(out_r)));
  // R8
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);
  // R8
  underrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(tick));
endmodule

bind wt_osc wt_osc_chk #(.ADDR_W(ADDR_W), .OUT_W(OUT_W)) u_chk (.*);

// File: tb/wt_osc_bench.sv
`timescale 1ns/1ps
module wt_osc_bench;
  logic clk = 0, rst_n = 0, tick = 0, rsp_valid = 0;
  logic [31:0] inc = 0, base = 32'h1000_0000, rsp_data = 0;
  logic [15:0] gain = 0;
  wire rd_req, out_valid, underrun;
  wire [31:0] rd_addr;
  wire [23:0] out_l, out_r;

  wt_osc u_wt_osc (.clk(clk), .rst_n(rst_n), .tick(tick), .phase_inc(inc), .gain(gain),
    .base_addr(base), .rd_req(rd_req), .rd_addr(rd_addr), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .out_valid(out_valid), .out_l(out_l), .out_r(out_r),
    .underrun(underrun));

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0, ovr = 0;
  logic [31:0] ovr_word = 0, ph = 0;

  function automatic logic [31:0] word_of(logic [13:0] i);
    return ovr ? ovr_word : (({18'd0, i} * 32'd2654435761) ^ 32'h3C5A_96E1);
  endfunction

  function automatic logic [23:0] scale(logic [31:0] w, logic [15:0] g);
    longint p;
    p = longint'($signed(w)) * longint'({1'b0, g});
    p = p >>> 23;
    if (p > 64'sd8388607) p = 64'sd8388607;
    if (p < -64'sd8388608) p = -64'sd8388608;
    return p[23:0];
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(output logic [13:0] idx);
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
    idx = ph[31:18];
    chk(rd_req == 1'b1, "R2 request pulse", rd_req, 1);
    chk(rd_addr == base + {16'd0, idx, 2'b00}, "R3 R4 address", rd_addr, base + {16'd0, idx, 2'b00});
    ph = ph + inc;
  endtask

  task automatic answer(logic [13:0] idx, int lat);
    bit held = 1;
    logic [23:0] prev = out_l, e;
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      if (out_valid || out_l != prev || out_r != prev || rd_req) held = 0;
    end
    chk(held, "R7 R2 hold while waiting", held, 1);
    rsp_valid = 1; rsp_data = word_of(idx);
    e = scale(rsp_data, gain);
    @(negedge clk) rsp_valid = 0;
    chk(out_valid == 1'b1, "R5 strobe", out_valid, 1);
    chk(out_l == e, "R5 left", out_l, e);
    chk(out_r == e, "R5 right", out_r, e);
  endtask

  initial begin
    logic [31:0] incs [4] = '{32'd39370534, 32'h0004_0000, 32'h0123_4567, 32'hC000_0000};
    logic [15:0] gains [4] = '{16'h2000, 16'h8000, 16'hFFFF, 16'h0000};
    logic [13:0] i1, i2;
    logic [23:0] e;
    repeat (3) @(negedge clk);
    chk(rd_req == 0 && out_valid == 0 && underrun == 0, "R1 reset controls", {rd_req, out_valid, underrun}, 0);
    chk(out_l == 0 && out_r == 0, "R1 reset outputs", out_l, 0);
    rst_n = 1;
    @(negedge clk);
    chk(rd_req == 0, "R2 no tick no request", rd_req, 0);

    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int s = 0; s < 6; s++) begin
          inc = incs[a]; gain = gains[b];
          issue(i1);
          answer(i1, (s + a + b) % 5);
        end

    ovr = 1; gain = 16'hFFFF; ovr_word = 32'h7FFF_FFFF;
    issue(i1); answer(i1, 1);
    chk(out_l == 24'h7FFFFF, "R6 positive clip", out_l, 24'h7FFFFF);
    ovr_word = 32'h8000_0000;
    issue(i1); answer(i1, 2);
    chk(out_l == 24'h800000, "R6 negative clip", out_l, 24'h800000);
    gain = 16'h8000; ovr_word = 32'h7FFF_FFFF;
    issue(i1); answer(i1, 0);
    chk(out_l == 24'h7FFFFF, "R6 unity edge", out_l, 24'h7FFFFF);
    ovr = 0;

    chk(underrun == 0, "R8 no underrun yet", underrun, 0);
    gain = 16'h2000; inc = 32'h0123_4567;
    issue(i1);
    rsp_valid = 1; rsp_data = word_of(i1); tick = 1;
    e = scale(rsp_data, gain);
    @(negedge clk) begin rsp_valid = 0; tick = 0; end
    chk(out_l == e && out_valid, "R8 same-cycle answer output", out_l, e);
    chk(underrun == 0, "R8 same-cycle answer no underrun", underrun, 0);
    i2 = ph[31:18];
    chk(rd_req == 1 && rd_addr == base + {16'd0, i2, 2'b00}, "R3 overlapped request", rd_addr, base + {16'd0, i2, 2'b00});
    ph = ph + inc;
    answer(i2, 2);

    issue(i1); issue(i2);
    chk(underrun == 1, "R8 underrun set", underrun, 1);
    answer(i1, 0); answer(i2, 1);
    issue(i1); answer(i1, 3);
    chk(underrun == 1, "R8 underrun sticky", underrun, 1);

    @(negedge clk) rst_n = 0;
    repeat (2) @(negedge clk);
    chk(underrun == 0 && out_l == 0 && out_valid == 0, "R1 reset clears", {underrun, out_l}, 0);
    rst_n = 1; ph = 0; inc = 32'h0004_0000;
    issue(i1);
    chk(i1 == 0, "R3 first index after reset", i1, 0);
    answer(i1, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule